// File: doc/BRIEF.md
# Stepped Sine Sample Generator

The block reads a 256-entry, 8-bit sine table and sends one sample at a time to an 8-bit parallel port. The port feeds a resistor-ladder DAC. A resolution code picks how many table entries one period visits: 256, 128, 64, 32, 16 or 8. It does this by reading every first, second, fourth, and so on entry. A delay constant sets how long each sample is held. The hold lasts 4×delay+13 clocks. The output frequency is therefore clock / (samples_per_period × (4×delay+13)). At a 16 MHz clock, 128 samples with a delay of 28 gives exactly 1 kHz.

Parameters are first written into a holding register through a load strobe. A start pulse copies the held parameters into the active set and restarts the phase at table entry 0. A stop pulse halts output at once. The last code stays on the port, so the ladder keeps a steady voltage. Each new code comes with a one-clock strobe.

Top module: `sine_ladder_gen`

## Requirements
- R1: While `rst` is high, at the next clock edge `sample_out` becomes 128 (mid-scale), `sample_stb` becomes 0 and `running` becomes 0.
- R2: Table entry k (0..255) equals 128 + floor(127·sin(2πk/256) + 0.5). Every emitted code is one of these entries.
- R3: The 3-bit `load_res` code c selects an index step of 2^c for c = 0..5 (256, 128, 64, 32, 16, 8 samples per period). Codes 6 and 7 behave like code 5. The index wraps modulo 256.
- R4: Take a start that is sampled at clock edge E. The first sample, table entry 0, appears after edge E+1. Each later sample follows the one before it by exactly 4·D+13 clocks. A delay D of 0 counts as 2^DELAY_W (65536 by default).
- R5: `sample_stb` is high for exactly one clock with each sample update. `sample_out` never changes without it.
- R6: A `stop` sampled at an edge clears `running` at that edge, and no strobe follows. Stop wins over a sample that falls due in the same cycle, and over a `start` in the same cycle.
- R7: While `running` is low, `sample_out` keeps its last value.
- R8: `load_en` stores `load_res` and `load_delay` but does not change a run in progress. A start in the same cycle as a load uses the values being loaded.
- R9: A start while running restarts the run: the index goes back to 0 and the delay count starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Store resolution code and delay in the holding register |
| load_res | input | 3 | Resolution code (0 = 256 samples ... 5 = 8 samples) |
| load_delay | input | DELAY_W | Delay constant, 0 means 2^DELAY_W |
| start | input | 1 | Begin or restart a run with the held parameters |
| stop | input | 1 | Halt sample output immediately |
| sample_out | output | DATA_W | Code for the resistor ladder |
| sample_stb | output | 1 | One-clock pulse with each new code |
| running | output | 1 | A run is active |

## Verification
Two pairs of events can land in the same cycle. The first pair is a sample falling due and a stop. The bench drives `stop` on the exact clock in which its model's countdown reaches its final step. Because stop wins, no strobe may follow and `sample_out` must keep its old code. The second pair is a load and a start. The bench drives both in one clock and checks the next sample gap against the period of the new delay, not the period of the held one. A start together with a stop is also provoked, and `running` must stay low.

// File: rtl/sine_gen_pkg.sv
package sine_gen_pkg;

  // Resolution codes: index stride is 2**code
  typedef enum logic [2:0] {
    RES_256 = 3'd0,
    RES_128 = 3'd1,
    RES_64  = 3'd2,
    RES_32  = 3'd3,
    RES_16  = 3'd4,
    RES_8   = 3'd5
  } res_code_e;

  localparam logic [2:0] MAX_SHIFT = 3'(RES_8);

  // Map a raw code to the stride shift, saturating unused codes
  function automatic logic [2:0] stride_shift(input logic [2:0] code);
    return (code > MAX_SHIFT) ? MAX_SHIFT : code;
  endfunction

  // Unsigned sine code for table position k of 2**aw, data width dw
  function automatic int sine_code(input int k, input int aw, input int dw);
    real ph;
    int  mid;
    ph  = 6.283185307179586 * real'(k) / (2.0 ** aw);
    mid = 1 << (dw - 1);
    return mid + int'($floor(real'(mid - 1) * $sin(ph) + 0.5));
  endfunction

endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);
  import sine_gen_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(sine_code(i, ADDR_W, DATA_W));
    end
  end

  // Registered read with synchronous reset of the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= MID;
    end else if (rd_en) begin
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/sample_pacer.sv
module sample_pacer #(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               halt,
  input  logic [DELAY_W-1:0] dly,
  output logic               tick,
  output logic               running
);
  localparam int CNT_W = DELAY_W + 3;

  logic [DELAY_W:0]   dly_eff;
  logic [CNT_W-1:0]   reload;
  logic [CNT_W-1:0]   cnt;

  // Zero delay stands for the full 2**DELAY_W
  assign dly_eff = (dly == '0) ? {1'b1, {DELAY_W{1'b0}}} : {1'b0, dly};
  // Period is 4*D+13 clocks; counter reloads with period-1
  assign reload  = {dly_eff, 2'b00} + CNT_W'(12);

  assign tick = running && (cnt == '0) && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (halt) begin
      running <= 1'b0;
    end else if (go) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

endmodule

// File: rtl/phase_step.sv
module phase_step #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              adv,
  input  logic [2:0]        shift,
  output logic [ADDR_W-1:0] idx
);
  logic [ADDR_W-1:0] stride;

  assign stride = ADDR_W'(1) << shift;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx <= '0;
    end else if (adv) begin
      idx <= idx + stride;
    end
  end

endmodule

// File: rtl/sine_ladder_gen.sv
module sine_ladder_gen #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [2:0]         load_res,
  input  logic [DELAY_W-1:0] load_delay,
  input  logic               start,
  input  logic               stop,
  output logic [DATA_W-1:0]  sample_out,
  output logic               sample_stb,
  output logic               running
);
  import sine_gen_pkg::*;

  logic [2:0]         hold_res,  act_shift;
  logic [DELAY_W-1:0] hold_dly,  act_dly;
  logic               go, tick;
  logic [ADDR_W-1:0]  idx;

  assign go = start && !stop;

  // Holding and active parameter sets; start copies, bypassing a same-cycle load
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_res  <= '0;
      hold_dly  <= '0;
      act_shift <= '0;
      act_dly   <= '0;
    end else begin
      if (load_en) begin
        hold_res <= load_res;
        hold_dly <= load_delay;
      end
      if (go) begin
        act_shift <= stride_shift(load_en ? load_res : hold_res);
        act_dly   <= load_en ? load_delay : hold_dly;
      end
    end
  end

  sample_pacer #(.DELAY_W(DELAY_W)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .halt    (stop),
    .dly     (act_dly),
    .tick    (tick),
    .running (running)
  );

  phase_step #(.ADDR_W(ADDR_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (go),
    .adv     (tick),
    .shift   (act_shift),
    .idx     (idx)
  );

  sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk   (clk),
    .rst   (rst),
    .rd_en (tick),
    .addr  (idx),
    .q     (sample_out)
  );

  always_ff @(posedge clk) begin
    if (rst) sample_stb <= 1'b0;
    else     sample_stb <= tick;
  end

endmodule

// File: rtl/sine_gen_checker.sv
module sine_gen_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              stop,
  input logic [DATA_W-1:0] sample_out,
  input logic              sample_stb,
  input logic              running
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sample_out == MID && !sample_stb && !running));

  a_r5_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_out) |-> sample_stb);

  a_r4_no_adjacent_strobes: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> running);

  a_r4_first_sample: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) ##1 !stop |=> sample_stb);

  a_r6_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!running && !sample_stb));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(sample_out));

endmodule

bind sine_ladder_gen sine_gen_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .stop       (stop),
  .sample_out (sample_out),
  .sample_stb (sample_stb),
  .running    (running)
);

// File: tb/test_sine_ladder_gen.sv
module test_sine_ladder_gen;
  localparam int DW = 8;
  localparam int LW = 8;   // shorter delay keeps the zero-delay case affordable

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [2:0]    load_res = '0;
  logic [LW-1:0] load_delay = '0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic [DW-1:0] sample_out;
  logic          sample_stb;
  logic          running;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sine_ladder_gen #(.DATA_W(DW), .ADDR_W(8), .DELAY_W(LW)) i_sine_ladder_gen (
    .clk(clk), .rst(rst), .load_en(load_en), .load_res(load_res),
    .load_delay(load_delay), .start(start), .stop(stop),
    .sample_out(sample_out), .sample_stb(sample_stb), .running(running)
  );

  // ---------------- behavioural reference ----------------
  int tab [256];
  int m_out, m_stb, m_run, m_wait, m_idx, m_step, m_period;
  int h_code, h_dly;

  function automatic int period_of(int d);
    return 4 * ((d == 0) ? (1 << LW) : d) + 13;
  endfunction

  function automatic int step_of(int c);
    return 1 << ((c > 5) ? 5 : c);
  endfunction

  initial begin
    for (int k = 0; k < 256; k++)
      tab[k] = 128 + int'($floor(127.0 * $sin(6.283185307179586 * k / 256.0) + 0.5));
  end

  always @(posedge clk) begin
    if (rst) begin
      m_out = 128; m_stb = 0; m_run = 0; m_wait = 0; m_idx = 0;
      m_step = 1; m_period = period_of(0); h_code = 0; h_dly = 0;
    end else begin
      m_stb = 0;
      if (stop) begin
        m_run = 0;
      end else if (start) begin
        m_run = 1; m_wait = 1; m_idx = 0;
        m_step   = step_of(load_en ? int'(load_res) : h_code);
        m_period = period_of(load_en ? int'(load_delay) : h_dly);
      end else if (m_run != 0) begin
        m_wait--;
        if (m_wait == 0) begin
          m_out = tab[m_idx]; m_stb = 1;
          m_idx = (m_idx + m_step) % 256;
          m_wait = m_period;
        end
      end
      if (load_en) begin
        h_code = int'(load_res); h_dly = int'(load_delay);
      end
    end
  end

  // Compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    checks++;
    if (int'(sample_out) != m_out) begin
      failures++;
      $display("FAIL R2/R3 sample_out got %0d exp %0d at %0t", sample_out, m_out, $time);
    end
    checks++;
    if (int'(sample_stb) != m_stb) begin
      failures++;
      $display("FAIL R5 sample_stb got %0d exp %0d at %0t", sample_stb, m_stb, $time);
    end
    checks++;
    if (int'(running) != m_run) begin
      failures++;
      $display("FAIL R6 running got %0d exp %0d at %0t", running, m_run, $time);
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic do_load(input int code, input int dly);
    @(negedge clk); load_en = 1; load_res = 3'(code); load_delay = LW'(dly);
    @(negedge clk); load_en = 0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic load_and_start(input int code, input int dly);
    @(negedge clk); load_en = 1; load_res = 3'(code); load_delay = LW'(dly); start = 1;
    @(negedge clk); load_en = 0; start = 0;
  endtask

  task automatic wait_stb(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!sample_stb);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 run did not complete got 0 exp 1");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int n, held;
    repeat (4) @(negedge clk);
    // R1: reset values
    check(sample_out == 8'd128 && !sample_stb && !running, "R1 reset state", int'(sample_out), 128);
    rst = 0;

    // R2/R4: 256 samples, delay 1 -> period 17, first code entry 0
    do_load(0, 1);
    do_start();
    wait_stb(n);
    check(int'(sample_out) == tab[0], "R2 first code", int'(sample_out), tab[0]);
    wait_stb(n);
    check(n == 17, "R4 gap d=1", n, 17);
    check(int'(sample_out) == tab[1], "R3 stride 1", int'(sample_out), tab[1]);
    repeat (256 * 17 + 40) @(posedge clk);

    // R8: load alone leaves the running period untouched
    do_load(1, 28);
    wait_stb(n); wait_stb(n);
    check(n == 17, "R8 load without start", n, 17);

    // 128 samples, delay 28 -> period 125
    do_start();
    wait_stb(n); wait_stb(n);
    check(n == 125, "R4 gap d=28", n, 125);
    check(int'(sample_out) == tab[2], "R3 stride 2", int'(sample_out), tab[2]);
    repeat (128 * 125 + 20) @(posedge clk);

    // R8 + R4: load and start together, delay 0 means 2**LW
    load_and_start(5, 0);
    wait_stb(n); wait_stb(n);
    check(n == 1037, "R4 zero delay", n, 1037);
    check(int'(sample_out) == tab[32], "R8 same-cycle load", int'(sample_out), tab[32]);
    repeat (8 * 1037 + 10) @(posedge clk);

    // R3: unused code 7 acts as 8 samples
    load_and_start(7, 2);
    wait_stb(n); wait_stb(n);
    check(n == 21, "R4 gap d=2", n, 21);
    check(int'(sample_out) == tab[32], "R3 code 7 stride", int'(sample_out), tab[32]);
    wait_stb(n);

    // R6: stop in the cycle a sample falls due
    @(negedge clk);
    while (!(m_run != 0 && m_wait == 1)) @(negedge clk);
    stop = 1;
    held = int'(sample_out);
    @(posedge clk); #1;
    check(!sample_stb && !running, "R6 stop beats due sample", int'(sample_stb), 0);
    @(negedge clk); stop = 0;
    // R7: output holds while idle
    repeat (60) @(negedge clk);
    check(int'(sample_out) == held && !running, "R7 hold while stopped", int'(sample_out), held);

    // R9: restart while running
    load_and_start(2, 3);
    repeat (3) wait_stb(n);
    do_start();
    wait_stb(n);
    check(int'(sample_out) == tab[0], "R9 restart at entry 0", int'(sample_out), tab[0]);
    wait_stb(n);
    check(n == 25 && int'(sample_out) == tab[4], "R9 restart stride and gap", n, 25);

    // R6: stop and start together, stop wins
    @(negedge clk); stop = 1; start = 1;
    @(posedge clk); #1;
    check(!running, "R6 stop beats start", int'(running), 0);
    @(negedge clk); stop = 0; start = 0;
    repeat (30) @(negedge clk);
    check(!running && !sample_stb, "R6 remains stopped", int'(running), 0);

    finish_run();
  end

endmodule